// File: doc/BRIEF.md
# Signed shift-count formation unit

This combinational unit turns the shift operand of an instruction into the two values a shifter needs: an 8-bit distance and a flag that reverses the direction. The base count is either a 15-bit signed literal, widened to 24 bits by copying its sign, or a 24-bit substitute value. An optional internal modifier and an optional external modifier are added to the base, all modulo 2^24. The external modifier is taken either as its full 24 bits or as only its low 15 bits with zeros above them.

A negative total is negated and marks the direction as reversed. Any magnitude above 255 is folded into the 8-bit range: bit 7 of the output is set whenever any of bits 23 down to 7 of the magnitude is set, and bits 6 to 0 pass through unchanged. This bounds the largest shift that the downstream unit ever performs. The downstream shifter XORs the reverse flag with the nominal direction of the function.

Top module: `shift_count_former`

## Requirements
- R1: With substitution off and both modifiers off, the count is the 15-bit literal sign-extended, so `rev_o` equals literal bit 14.
- R2: With substitution on, the 24-bit substitute value replaces the literal, and the literal has no effect on the outputs.
- R3: With the internal modifier enabled, its 24-bit value is added to the base count modulo 2^24.
- R4: With the external modifier enabled and `xmod_wide_i` low, only bits 14..0 of `xmod_val_i` are added, zero-extended. Bits 23..15 have no effect.
- R5: With the external modifier enabled and `xmod_wide_i` high, all 24 bits of `xmod_val_i` are added.
- R6: If bit 23 of the total is 1, `rev_o` is 1 and the magnitude is taken from the two's-complement negation of the total.
- R7: A magnitude in the range 0..255 appears unchanged on `mag_o`.
- R8: A magnitude above 255 gives `mag_o` = 128 + (magnitude mod 128).
- R9: The total 0x800000 gives `mag_o` = 0x80 and `rev_o` = 1.
- R10: A total of zero gives `mag_o` = 0 and `rev_o` = 0.
- R11: A modifier whose enable is low has no effect on the outputs, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lit_i | input | 15 | Signed literal count |
| repl_en_i | input | 1 | Use the substitute value instead of the literal |
| repl_val_i | input | 24 | Substitute count |
| imod_en_i | input | 1 | Add the internal modifier |
| imod_val_i | input | 24 | Internal modifier |
| xmod_en_i | input | 1 | Add the external modifier |
| xmod_wide_i | input | 1 | 1: add all 24 bits; 0: add the low 15 bits, zero-extended |
| xmod_val_i | input | 24 | External modifier |
| mag_o | output | 8 | Folded shift magnitude |
| rev_o | output | 1 | Reverse the nominal direction |

## Verification
The checker runs on every input change and looks at cases where no modifier is active. In those cases the expected outputs follow directly from the ports: the sign of the literal or substitute, exact small counts, folding of large substitutes, the most negative value, and zero. Carries across the modifier sums, the narrow external operand whose upper bits are masked, and negation of totals made from several operands can only be shown by the bench's directed and random scenarios, which are checked against a reference model.

// File: rtl/shift_count_former.sv
module shift_count_former #(
  parameter int LIT_W = 15,
  parameter int CNT_W = 24,
  parameter int MAG_W = 8
) (
  input  logic [LIT_W-1:0] lit_i,
  input  logic             repl_en_i,
  input  logic [CNT_W-1:0] repl_val_i,
  input  logic             imod_en_i,
  input  logic [CNT_W-1:0] imod_val_i,
  input  logic             xmod_en_i,
  input  logic             xmod_wide_i,
  input  logic [CNT_W-1:0] xmod_val_i,
  output logic [MAG_W-1:0] mag_o,
  output logic             rev_o
);
  localparam int EXT_W = CNT_W - LIT_W;
  localparam int TOP   = MAG_W - 1;

  logic [CNT_W-1:0] base, imod, xmod, total, absval;
  logic             fold;

  assign base   = repl_en_i ? repl_val_i : {{EXT_W{lit_i[LIT_W-1]}}, lit_i};
  assign imod   = imod_en_i ? imod_val_i : '0;
  assign xmod   = !xmod_en_i  ? '0
                : xmod_wide_i ? xmod_val_i
                :               {{EXT_W{1'b0}}, xmod_val_i[LIT_W-1:0]};
  assign total  = base + imod + xmod;
  assign rev_o  = total[CNT_W-1];
  assign absval = rev_o ? (~total + 1'b1) : total;
  assign fold   = |absval[CNT_W-1:TOP];
  assign mag_o  = {fold, absval[TOP-1:0]};
endmodule

// File: rtl/shift_count_former_chk.sv
module shift_count_former_chk #(
  parameter int LIT_W = 15,
  parameter int CNT_W = 24,
  parameter int MAG_W = 8
) (
  input logic [LIT_W-1:0] lit_i,
  input logic             repl_en_i,
  input logic [CNT_W-1:0] repl_val_i,
  input logic             imod_en_i,
  input logic             xmod_en_i,
  input logic [MAG_W-1:0] mag_o,
  input logic             rev_o
);
  localparam int TOP = MAG_W - 1;
  logic no_mod;
  assign no_mod = !imod_en_i && !xmod_en_i;

  always_comb begin
    if (no_mod && !repl_en_i)
      p_lit_sign_r1: assert (rev_o == lit_i[LIT_W-1]);
    if (no_mod && repl_en_i)
      p_repl_sign_r2: assert (rev_o == repl_val_i[CNT_W-1]);
    if (no_mod && !repl_en_i && !lit_i[LIT_W-1] && lit_i < (1 << MAG_W))
      p_small_exact_r7: assert (mag_o == lit_i[MAG_W-1:0] && !rev_o);
    if (no_mod && repl_en_i && !repl_val_i[CNT_W-1] && repl_val_i >= (1 << MAG_W))
      p_fold_r8: assert (mag_o[TOP] && mag_o[TOP-1:0] == repl_val_i[TOP-1:0]);
    if (no_mod && repl_en_i && repl_val_i == {1'b1, {(CNT_W-1){1'b0}}})
      p_most_neg_r9: assert (mag_o == {1'b1, {TOP{1'b0}}} && rev_o);
    if (no_mod && !repl_en_i && lit_i == '0)
      p_zero_r10: assert (mag_o == '0 && !rev_o);
  end
endmodule

bind shift_count_former shift_count_former_chk #(
  .LIT_W(LIT_W), .CNT_W(CNT_W), .MAG_W(MAG_W)
) u_chk (
  .lit_i(lit_i), .repl_en_i(repl_en_i), .repl_val_i(repl_val_i),
  .imod_en_i(imod_en_i), .xmod_en_i(xmod_en_i),
  .mag_o(mag_o), .rev_o(rev_o)
);

// File: tb/sim_shift_count_former.sv
module sim_shift_count_former;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [14:0] lit;
  logic        repl_en, imod_en, xmod_en, xmod_wide;
  logic [23:0] repl_val, imod_val, xmod_val;
  logic [7:0]  mag;
  logic        rev;
  int checks = 0, errors = 0;
  bit done = 0;

  shift_count_former u0 (
    .lit_i(lit), .repl_en_i(repl_en), .repl_val_i(repl_val),
    .imod_en_i(imod_en), .imod_val_i(imod_val),
    .xmod_en_i(xmod_en), .xmod_wide_i(xmod_wide), .xmod_val_i(xmod_val),
    .mag_o(mag), .rev_o(rev)
  );

  function automatic logic [23:0] ref_total();
    logic [23:0] t;
    t = repl_en ? repl_val : 24'($signed(lit));
    if (imod_en) t = t + imod_val;
    if (xmod_en) t = t + (xmod_wide ? xmod_val : {9'd0, xmod_val[14:0]});
    return t;
  endfunction

  function automatic logic [8:0] ref_out();
    logic [23:0] t, a;
    t = ref_total();
    a = t[23] ? 24'(0) - t : t;
    if (a > 24'd255) return {t[23], 1'b1, a[6:0]};
    return {t[23], a[7:0]};
  endfunction

  task automatic drive(input logic [14:0] l, input logic re, input logic [23:0] rv,
                       input logic ie, input logic [23:0] iv,
                       input logic xe, input logic xw, input logic [23:0] xv);
    @(negedge clk);
    lit = l; repl_en = re; repl_val = rv; imod_en = ie; imod_val = iv;
    xmod_en = xe; xmod_wide = xw; xmod_val = xv;
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [8:0] exp);
    checks++;
    if ({rev, mag} !== exp) begin
      errors++;
      $display("FAIL %s: rev=%0b mag=%0d expected rev=%0b mag=%0d",
               tag, rev, mag, exp[8], exp[7:0]);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    lit = '0; repl_en = 0; repl_val = '0; imod_en = 0; imod_val = '0;
    xmod_en = 0; xmod_wide = 0; xmod_val = '0;
    repeat (3) @(posedge clk); rst_n = 1'b1;
    #1 check("R10 reset state", 9'h000);

    drive(15'd5, 0, 0, 0, 0, 0, 0, 0);                 check("R1 R7 small literal", {1'b0, 8'd5});
    drive(15'h7FFD, 0, 0, 0, 0, 0, 0, 0);              check("R1 R6 literal -3", {1'b1, 8'd3});
    drive(15'd255, 0, 0, 0, 0, 0, 0, 0);               check("R7 255 edge", {1'b0, 8'd255});
    drive(15'd256, 0, 0, 0, 0, 0, 0, 0);               check("R8 256 edge", {1'b0, 8'd128});
    drive(15'h7F00, 0, 0, 0, 0, 0, 0, 0);              check("R8 literal -256", {1'b1, 8'd128});
    drive(15'h1234, 1, 24'd7, 0, 0, 0, 0, 0);          check("R2 substitute", {1'b0, 8'd7});
    drive(15'h7FFF, 1, 24'h800000, 0, 0, 0, 0, 0);     check("R9 most negative", {1'b1, 8'h80});
    drive(15'd10, 0, 0, 1, 24'hFFFFF6, 0, 0, 0);       check("R3 R10 sum wraps to 0", 9'h000);
    drive(15'd1, 0, 0, 1, 24'hFFFFFF, 1, 1, 24'hFFFFFF); check("R3 R5 sums negative", {1'b1, 8'd1});
    drive(15'd0, 0, 0, 0, 0, 1, 0, 24'hFF8003);        check("R4 narrow ignores upper", {1'b0, 8'd3});
    drive(15'd0, 0, 0, 0, 0, 1, 0, 24'h007FFF);        check("R4 narrow not sign extended", {1'b0, 8'hFF});
    drive(15'd0, 0, 0, 0, 0, 1, 1, 24'hFF8003);        check("R5 wide operand", {1'b1, 8'hFD});
    drive(15'd4, 0, 0, 0, 24'h123456, 0, 1, 24'h00ABCD); check("R11 disabled modifiers", {1'b0, 8'd4});
    drive(15'd0, 1, 24'h7FFFFF, 0, 0, 0, 0, 0);        check("R8 largest positive", {1'b0, 8'hFF});

    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] rv, iv, xv;
      logic [14:0] l;
      logic [8:0] e;
      rv = $urandom; iv = $urandom; xv = $urandom; l = 15'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        rv = 24'($signed(10'($urandom)));
        iv = 24'($signed(9'($urandom)));
        xv = 24'($urandom_range(0, 200));
        l  = 15'($signed(9'($urandom)));
      end
      drive(l, 1'($urandom), rv, 1'($urandom), iv, 1'($urandom), 1'($urandom), xv);
      e = ref_out();
      check(e[8] ? "R6 random" : (e[7] && ref_total() > 24'd255) ? "R8 random" : "R7 random", e);
    end
    finish_up();
  end
endmodule